// File: doc/BRIEF.md
# Cascaded Reload Timer with Interrupt

This block produces a constant-period interrupt from a two-stage divider chain. A fixed divide-by-three prescaler turns the system clock into an instruction-rate tick. That tick decrements a free-running wide timer, which wraps every 2^WIDE_W ticks. When the control register selects it, the wide timer's underflow pulse is the count tick for an 8-bit down-counter that reloads from a programmable register. Each underflow of that counter sets a request flag. The flag drives the interrupt output only when a per-timer enable and a global enable are both set.

A CPU talks to the block over a simple register bus with four write addresses: control, reload, timer enable and global enable. A separate test-and-clear strobe returns the current flag value and clears the flag in the same access. For example, with a 4 MHz clock, WIDE_W = 16 and a reload value of 39, the interrupt period is 3·65536·40 cycles, which is about 2 s.

Top module: `cascade_irq_timer`

## Requirements
- R1: After reset, the control, reload, timer enable and global enable registers, the request flag and the count all read 0, and irq_o is low.
- R2: The prescaler emits one tick every 3 clock cycles. The wide timer underflows once every 2^WIDE_W ticks. When the control source field ctrl[1:0] is 2'b11, the reload counter therefore receives one count tick every 3·2^WIDE_W cycles.
- R3: While the counter runs with reload value N, consecutive settings of the request flag are exactly 3·2^WIDE_W·(N+1) clock cycles apart. At each underflow the count is reloaded with N.
- R4: A write to address 0 that sets bit 3 (the run bit) while that bit is 0 loads the reload value into the count at the same clock edge.
- R5: While the run bit is 0, the count holds its value and the flag is not set by the counter.
- R6: A source code in ctrl[1:0] other than 2'b11 delivers no count ticks, so the count holds and the flag stays clear.
- R7: A write to address 1 while the counter runs leaves the current count unchanged. The new value is used from the next reload onward.
- R8: While tc_i is high, tc_hit_o equals the request flag. At the following edge the flag is cleared.
- R9: If an underflow and a test-and-clear access fall on the same edge, the flag stays set.
- R10: irq_o is high exactly when the flag, the timer enable (address 2, bit 0) and the global enable (address 3, bit 0) are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 control, 1 reload, 2 timer enable, 3 global enable |
| wr_data_i | input | CNT_W | Write data |
| tc_i | input | 1 | Test-and-clear strobe for the request flag |
| tc_hit_o | output | 1 | Flag value reported during a test-and-clear access |
| req_o | output | 1 | Request flag |
| irq_o | output | 1 | Gated interrupt output |
| cnt_o | output | CNT_W | Current reload-counter value |

## Verification
The period is measured between consecutive flag settings for reload values 0, 3 and 5. This separates the prescaler ratio, the wide-timer wrap length and the N+1 reload behaviour, since each stage scales the interval differently. A mid-run reload write is checked both for an unchanged current count and for a new interval of 10 periods. Stopping, restarting and selecting a non-timer source each show whether ticks are gated or the count is disturbed. All four enable combinations are applied while the flag is held set. A test-and-clear strobe is placed exactly on an underflow edge to tell set priority from clear priority.

// File: rtl/cascade_irq_timer_pkg.sv
package cascade_irq_timer_pkg;

  typedef enum logic [1:0] {
    SRC_NONE0   = 2'b00,
    SRC_NONE1   = 2'b01,
    SRC_NONE2   = 2'b10,
    SRC_WIDE_UF = 2'b11
  } src_sel_e;

  typedef struct packed {
    logic     run;
    logic     spare;
    src_sel_e src;
  } ctrl_t;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_RELOAD = 2'd1;
  localparam logic [1:0] ADDR_IE     = 2'd2;
  localparam logic [1:0] ADDR_GIE    = 2'd3;

endpackage

// File: rtl/cpt_prescaler.sv
module cpt_prescaler #(
  parameter int unsigned DIV = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/cpt_wide_timer.sv
module cpt_wide_timer #(
  parameter int unsigned WIDE_W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic uf_o
);
  logic [WIDE_W-1:0] cnt_q;

  // free-running, wraps to all ones after zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '1;
    else if (tick_i) cnt_q <= cnt_q - 1'b1;
  end

  assign uf_o = tick_i && (cnt_q == '0);
endmodule

// File: rtl/cpt_reload_counter.sv
module cpt_reload_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             uf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             step;

  assign step = run_i && tick_i && !start_i;
  assign uf_o = step && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (start_i) cnt_q <= reload_i;
    else if (uf_o)    cnt_q <= reload_i;
    else if (step)    cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/cpt_regs.sv
module cpt_regs
  import cascade_irq_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             tc_i,
  input  logic             set_i,
  output ctrl_t            ctrl_o,
  output logic [CNT_W-1:0] reload_o,
  output logic             start_o,
  output logic             ie_o,
  output logic             gie_o,
  output logic             flag_o,
  output logic             tc_hit_o,
  output logic             irq_o
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic             ie_q, gie_q, flag_q;
  logic             wr_ctrl, wr_reload, wr_ie, wr_gie;
  ctrl_t            ctrl_d;

  assign wr_ctrl   = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign wr_reload = wr_en_i && (wr_addr_i == ADDR_RELOAD);
  assign wr_ie     = wr_en_i && (wr_addr_i == ADDR_IE);
  assign wr_gie    = wr_en_i && (wr_addr_i == ADDR_GIE);
  assign ctrl_d    = ctrl_t'(wr_data_i[3:0]);

  assign start_o = wr_ctrl && ctrl_d.run && !ctrl_q.run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      ie_q     <= 1'b0;
      gie_q    <= 1'b0;
    end else begin
      if (wr_ctrl)   ctrl_q   <= ctrl_d;
      if (wr_reload) reload_q <= wr_data_i;
      if (wr_ie)     ie_q     <= wr_data_i[0];
      if (wr_gie)    gie_q    <= wr_data_i[0];
    end
  end

  // set wins over test-and-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (tc_i)  flag_q <= 1'b0;
  end

  assign ctrl_o   = ctrl_q;
  assign reload_o = reload_q;
  assign ie_o     = ie_q;
  assign gie_o    = gie_q;
  assign flag_o   = flag_q;
  assign tc_hit_o = tc_i && flag_q;
  assign irq_o    = flag_q && ie_q && gie_q;
endmodule

// File: rtl/cascade_irq_timer.sv
module cascade_irq_timer
  import cascade_irq_timer_pkg::*;
#(
  parameter int unsigned PRESC_DIV = 3,
  parameter int unsigned WIDE_W    = 16,
  parameter int unsigned CNT_W     = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             tc_i,
  output logic             tc_hit_o,
  output logic             req_o,
  output logic             irq_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             presc_tick;
  logic             wide_uf;
  logic             src_tick;
  logic             cnt_uf;
  logic             start;
  logic             ie, gie;
  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload;

  cpt_prescaler #(.DIV(PRESC_DIV)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (presc_tick)
  );

  cpt_wide_timer #(.WIDE_W(WIDE_W)) u_wide (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (presc_tick),
    .uf_o   (wide_uf)
  );

  // only the wide-timer underflow source is implemented
  assign src_tick = (ctrl.src == SRC_WIDE_UF) ? wide_uf : 1'b0;

  cpt_reload_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (ctrl.run),
    .start_i  (start),
    .tick_i   (src_tick),
    .reload_i (reload),
    .cnt_o    (cnt_o),
    .uf_o     (cnt_uf)
  );

  cpt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .tc_i      (tc_i),
    .set_i     (cnt_uf),
    .ctrl_o    (ctrl),
    .reload_o  (reload),
    .start_o   (start),
    .ie_o      (ie),
    .gie_o     (gie),
    .flag_o    (req_o),
    .tc_hit_o  (tc_hit_o),
    .irq_o     (irq_o)
  );
endmodule

// File: rtl/cpt_checker.sv
module cpt_checker #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             presc_tick,
  input logic             cnt_uf,
  input logic             start,
  input logic             run,
  input logic             tc_i,
  input logic             req_o,
  input logic             irq_o,
  input logic             ie,
  input logic             gie,
  input logic [CNT_W-1:0] cnt_o,
  input logic [CNT_W-1:0] reload
);
  // R2
  presc_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    presc_tick |=> !presc_tick);

  // R4
  start_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (cnt_o == $past(reload)));

  // R5
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !start) |=> $stable(cnt_o));

  // R8
  tc_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_i && !cnt_uf) |=> !req_o);

  // R9
  uf_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_uf |=> req_o);

  // R10
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (req_o && ie && gie));
endmodule

bind cascade_irq_timer cpt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .presc_tick (presc_tick),
  .cnt_uf     (cnt_uf),
  .start      (start),
  .run        (ctrl.run),
  .tc_i       (tc_i),
  .req_o      (req_o),
  .irq_o      (irq_o),
  .ie         (ie),
  .gie        (gie),
  .cnt_o      (cnt_o),
  .reload     (reload)
);

// File: tb/cascade_irq_timer_tb.sv
module cascade_irq_timer_tb;
  localparam int WIDE_W = 4;
  localparam int CNT_W  = 8;
  localparam int TICKP  = 3 * (1 << WIDE_W);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [1:0]       wr_addr = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic             tc = 1'b0;
  logic             tc_hit, req, irq;
  logic [CNT_W-1:0] cnt;

  int checks = 0;
  int errors = 0;
  int cyc_total = 0;

  always #5 clk = ~clk;

  cascade_irq_timer #(.WIDE_W(WIDE_W), .CNT_W(CNT_W)) u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .tc_i      (tc),
    .tc_hit_o  (tc_hit),
    .req_o     (req),
    .irq_o     (irq),
    .cnt_o     (cnt)
  );

  always @(posedge clk) cyc_total <= cyc_total + 1;

  initial begin
    wait (cyc_total >= 150000);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc_total);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  // all tasks start and end just after a negedge
  task automatic wr(input logic [1:0] a, input int d);
    wr_en = 1'b1; wr_addr = a; wr_data = CNT_W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clr();
    tc = 1'b1;
    @(negedge clk);
    tc = 1'b0;
  endtask

  task automatic wait_rise(output int n);
    n = 0;
    while (!req && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (!req) chk("wait for flag", 0, 1);
  endtask

  task automatic start_run(input int n);
    wr(2'd0, 4'h3);
    wr(2'd1, n);
    wr(2'd0, 4'hB);
  endtask

  task automatic t_reset();
    chk("R1 req", req, 0);
    chk("R1 irq", irq, 0);
    chk("R1 cnt", cnt, 0);
    chk("R1 tc_hit", tc_hit, 0);
  endtask

  task automatic t_period(input int n, input string rq);
    int d;
    start_run(n);
    chk("R4 load on start", cnt, n);
    clr();
    wait_rise(d);
    clr();
    wait_rise(d);
    chk(rq, d + 1, TICKP * (n + 1));
    chk("R3 reload at underflow", cnt, n);
    chk("R10 irq with enables off", irq, 0);
  endtask

  task automatic t_reload_write();
    int d;
    start_run(3);
    clr();
    wait_rise(d);
    wr(2'd1, 9);
    chk("R7 count kept", cnt, 3);
    clr();
    wait_rise(d);
    chk("R7 new reload used", cnt, 9);
    clr();
    wait_rise(d);
    chk("R7 new interval", d + 1, TICKP * 10);
  endtask

  task automatic t_stop();
    int d, held;
    start_run(9);
    clr();
    wait_rise(d);
    clr();
    repeat (100) @(negedge clk);
    wr(2'd0, 4'h3);
    held = cnt;
    repeat (300) @(negedge clk);
    chk("R5 count held", cnt, held);
    chk("R5 no flag", req, 0);
    wr(2'd0, 4'hB);
    chk("R4 restart loads", cnt, 9);
  endtask

  task automatic t_src();
    wr(2'd0, 4'h3);
    wr(2'd1, 2);
    wr(2'd0, 4'h8);
    clr();
    repeat (200) @(negedge clk);
    chk("R6 count held", cnt, 2);
    chk("R6 no flag", req, 0);
  endtask

  task automatic t_collision();
    int d;
    start_run(0);
    clr();
    wait_rise(d);
    repeat (TICKP - 1) @(negedge clk);
    tc = 1'b1;
    #1;
    chk("R8 tc_hit on set flag", tc_hit, 1);
    @(negedge clk);
    tc = 1'b0;
    chk("R9 flag kept", req, 1);
  endtask

  task automatic t_gate();
    int d;
    start_run(1);
    clr();
    wait_rise(d);
    wr(2'd0, 4'h3);
    wr(2'd2, 0); wr(2'd3, 0);
    chk("R10 00", irq, 0);
    wr(2'd2, 1);
    chk("R10 ie only", irq, 0);
    wr(2'd2, 0); wr(2'd3, 1);
    chk("R10 gie only", irq, 0);
    wr(2'd2, 1);
    chk("R10 both", irq, 1);
    tc = 1'b1;
    #1;
    chk("R8 hit while set", tc_hit, 1);
    @(negedge clk);
    tc = 1'b0;
    chk("R8 cleared", req, 0);
    chk("R10 irq drops", irq, 0);
    tc = 1'b1;
    #1;
    chk("R8 no hit when clear", tc_hit, 0);
    @(negedge clk);
    tc = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_period(0, "R2 interval N=0");
    t_period(3, "R3 interval N=3");
    t_period(5, "R3 interval N=5");
    t_reload_write();
    t_stop();
    t_src();
    t_collision();
    t_gate();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule